// File: doc/BRIEF.md
# Separate-I/O Quad-Data-Rate Burst SRAM

This block is a synthesizable behavioural model of a static RAM with a dedicated read port and a dedicated write port that share one address bus. Half-cycle timing is expressed on a single tick clock running at twice the command rate. After reset the first tick is an even tick, standing for the rising edge of the true input clock. Ticks then alternate with odd ticks, which stand for the rising edge of the complementary clock.

Commands are taken only on even ticks. A read takes its address on the command tick. A write takes its address on the following odd tick. Every access moves a fixed burst of four 36-bit words, one word per tick, so each port can start one burst every four ticks. Both ports run at the same time with no turnaround. A read that overlaps a write to the same words returns the new data as far as the write has progressed. A latency mode is sampled while reset is held: the pipelined mode or a shorter legacy mode. A valid flag leads the read words by one tick.

Top module: `qdr_burst_sram`

## Requirements
- R1: While reset is held, and on the first tick after it, `rd_valid` is 0 and `rd_data` is 0.
- R2: `wr_sel` high on an even tick starts a write burst. The write address is taken from `addr` on the next odd tick. The four `wr_data` words on that odd tick and the three ticks after it are stored, in order, into words 0 to 3 of location `addr[AW-1:2]`. The low two address bits are ignored.
- R3: Each write word is qualified by `wr_be`: bit n enables bits 9n+8 down to 9n. Bytes whose bit is 0 keep their previous contents.
- R4: In pipelined mode, a read accepted on even tick T (address `addr[AW-1:2]` on tick T) drives word k of the location on the tick after edge T+5+k, for k = 0..3. `rd_valid` is high on the ticks after edges T+4 to T+7.
- R5: In legacy mode, word k of a read accepted on tick T appears after edge T+3+k, and `rd_valid` is high after edges T+2 to T+5.
- R6: On every tick that carries no read word, `rd_data` is 0. `rd_valid` is low on every tick outside the windows of accepted reads.
- R7: A read or write request two ticks after an accepted request of the same kind is ignored: no output word appears and no location is changed. A request on an odd tick is also ignored.
- R8: A new request on the fourth tick after an accepted request of the same kind is accepted. For reads this gives a gap-free word stream and a continuously high `rd_valid`.
- R9: A read and a write may be accepted on the same tick to different locations, and each completes as if alone.
- R10: A read word reflects every write beat to that word captured on or before the edge that drives the word out, with byte enables applied. Later beats do not affect it.
- R11: `legacy_mode` is sampled only while reset is held (1 selects legacy). Changing it afterwards does not change the read latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock, two ticks per command cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| legacy_mode | input | 1 | Latency mode, sampled during reset: 1 legacy, 0 pipelined |
| rd_sel | input | 1 | Read request, sampled on even ticks |
| wr_sel | input | 1 | Write request, sampled on even ticks |
| addr | input | AW | Shared address: read address on even ticks, write address on odd ticks |
| wr_data | input | DW | Write word, one per tick during a write burst |
| wr_be | input | LANES | Byte enables for the current write word |
| rd_data | output | DW | Read word, zero when no read word is due |
| rd_valid | output | 1 | Read valid flag, one tick ahead of the words |

## Verification
The hardest case to reach is a write beat landing on the same word, on the same edge, that the read path drives out. The read and write commands must then sit exactly four ticks apart in pipelined mode and two ticks apart in legacy mode. The stimulus is laid out on an absolute tick schedule, so these offsets are placed exactly, together with one offset where the write lands earlier and one where it lands later. Ignored requests are placed two ticks into an active burst. They point at a location that was already written, so a wrong acceptance shows up either as extra valid ticks or as corrupted data on a later read.

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram #(
  parameter int DEPTH = 16,
  parameter int DW = 36,
  parameter int LANES = 4,
  parameter int AW = $clog2(DEPTH) + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             legacy_mode,
  input  logic             rd_sel,
  input  logic             wr_sel,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [LANES-1:0] wr_be,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid
);
  localparam int LW = DW / LANES;
  localparam int CW = AW - 2;
  localparam int WORDS = DEPTH * 4;
  localparam int DLY = 4;

  logic [DW-1:0] mem [WORDS];

  logic          ph, mode_q;
  logic [1:0]    rcnt;
  logic [2:0]    wcnt, vc;
  logic [DLY-1:0] go_sr;
  logic [CW-1:0] loc_sr [DLY];
  logic [CW-1:0] oloc, wloc;
  logic [DW-1:0] rdq;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                          input logic [DW-1:0] new_w,
                                          input logic [LANES-1:0] be);
    logic [DW-1:0] r;
    r = old_w;
    for (int i = 0; i < LANES; i++)
      if (be[i]) r[i*LW +: LW] = new_w[i*LW +: LW];
    return r;
  endfunction

  logic          even, rd_go, wr_go, start, wact, fwd;
  logic [CW-1:0] start_loc, wloc_cur;
  logic [1:0]    wbi, oidx;
  logic [AW-1:0] widx, ridx;
  logic [DW-1:0] rword;
  logic          unused_lo;

  assign unused_lo = ^addr[1:0];
  assign even      = ~ph;
  assign rd_go     = rd_sel & even & (rcnt == 2'd0);
  assign wr_go     = wr_sel & even & (wcnt <= 3'd1);
  assign start     = mode_q ? go_sr[1] : go_sr[DLY-1];
  assign start_loc = mode_q ? loc_sr[1] : loc_sr[DLY-1];

  assign wact      = wcnt != 3'd0;
  assign wloc_cur  = (wcnt == 3'd4) ? addr[AW-1:2] : wloc;
  assign wbi       = 2'(3'd4 - wcnt);
  assign widx      = {wloc_cur, wbi};

  assign oidx      = 2'(3'd4 - vc);
  assign ridx      = {oloc, oidx};
  assign fwd       = wact && (widx == ridx);
  assign rword     = fwd ? merge(mem[ridx], wr_data, wr_be) : mem[ridx];

  assign rd_data   = rdq;
  assign rd_valid  = vc != 3'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= 1'b0;
      mode_q <= legacy_mode;
      rcnt   <= '0;
      wcnt   <= '0;
      vc     <= '0;
      go_sr  <= '0;
      rdq    <= '0;
    end else begin
      ph    <= ~ph;
      go_sr <= {go_sr[DLY-2:0], rd_go};
      if (rd_go) rcnt <= 2'd3;
      else if (rcnt != 2'd0) rcnt <= rcnt - 2'd1;
      if (wr_go) wcnt <= 3'd4;
      else if (wact) wcnt <= wcnt - 3'd1;
      if (start) vc <= 3'd4;
      else if (vc != 3'd0) vc <= vc - 3'd1;
      rdq <= (vc != 3'd0) ? rword : '0;
    end
  end

  always_ff @(posedge clk) begin
    loc_sr[0] <= addr[AW-1:2];
    if (start) oloc <= start_loc;
    if (wcnt == 3'd4) wloc <= addr[AW-1:2];
    if (wact) mem[widx] <= merge(mem[widx], wr_data, wr_be);
  end

  for (genvar g = 1; g < DLY; g++) begin : g_locpipe
    always_ff @(posedge clk) loc_sr[g] <= loc_sr[g-1];
  end
endmodule

// File: rtl/qdr_burst_sram_chk.sv
module qdr_burst_sram_chk #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input logic          rd_go,
  input logic          wr_go,
  input logic          mode_q
);
  logic [1:0] vrun;
  logic [2:0] rgap, wgap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vrun <= '0;
      rgap <= 3'd7;
      wgap <= 3'd7;
    end else begin
      if (rd_valid) vrun <= vrun + 2'd1;
      rgap <= rd_go ? 3'd0 : ((rgap == 3'd7) ? rgap : rgap + 3'd1);
      wgap <= wr_go ? 3'd0 : ((wgap == 3'd7) ? wgap : wgap + 3'd1);
    end
  end

  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && !$past(rd_valid)) |-> rd_data == '0);

  // R4
  valid_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_valid) |-> vrun == 2'd0);

  // R7
  rd_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |-> rgap >= 3'd3);

  // R7
  wr_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> wgap >= 3'd3);

  // R11
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q));
endmodule

bind qdr_burst_sram qdr_burst_sram_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_data(rd_data),
  .rd_go(rd_go), .wr_go(wr_go), .mode_q(mode_q)
);

// File: tb/qdr_burst_sram_test.sv
`timescale 1ns/1ps
module qdr_burst_sram_test;
  localparam int NS = 256;

  logic        clk = 0, rst_n = 0, legacy_mode = 0, rd_sel = 0, wr_sel = 0;
  logic [5:0]  addr = '0;
  logic [35:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic [35:0] rd_data;
  logic        rd_valid;

  qdr_burst_sram uut (
    .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode), .rd_sel(rd_sel),
    .wr_sel(wr_sel), .addr(addr), .wr_data(wr_data), .wr_be(wr_be),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always #2.5 clk = ~clk;

  typedef struct { int first; int loc; string tag; } rd_item_t;
  rd_item_t q[$];

  bit          s_rd [NS], s_wr [NS], sh_on [NS];
  logic [5:0]  s_addr [NS], sh_idx [NS];
  logic [35:0] s_wd [NS], sh_d [NS];
  logic [3:0]  s_be [NS], sh_be [NS];
  string       idle_tag [NS];
  logic [35:0] shadow [64];

  int checks = 0, fails = 0, tk = -1, toggle_at = -1;

  always @(posedge clk) tk <= rst_n ? tk + 1 : -1;

  task automatic chk(string tag, string what, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [35:0] wv(int loc, int beat, int seed);
    return {8'(seed), 4'(beat), 8'(loc), 16'(seed * 40503 + beat * 4660 + 3870)};
  endfunction

  function automatic logic [35:0] bmerge(logic [35:0] o, logic [35:0] n, logic [3:0] be);
    logic [35:0] r = o;
    for (int i = 0; i < 4; i++) if (be[i]) r[i*9 +: 9] = n[i*9 +: 9];
    return r;
  endfunction

  task automatic sched_write(int t, int loc, int seed, logic [15:0] bes);
    s_wr[t] = 1;
    s_addr[t+1] = 6'(loc * 4 + 1);
    for (int i = 0; i < 4; i++) begin
      s_wd[t+1+i] = wv(loc, i, seed);
      s_be[t+1+i] = bes[4*i +: 4];
      sh_on[t+1+i] = 1;
      sh_idx[t+1+i] = 6'(loc * 4 + i);
      sh_d[t+1+i] = wv(loc, i, seed);
      sh_be[t+1+i] = bes[4*i +: 4];
    end
  endtask

  task automatic sched_read(int t, int loc, int lat, string tag);
    s_rd[t] = 1;
    s_addr[t] = 6'(loc * 4 + 3);
    q.push_back('{first: t + lat, loc: loc, tag: tag});
  endtask

  task automatic mark_quiet(int a, int b);
    for (int i = a; i <= b; i++) idle_tag[i] = "R7";
  endtask

  task automatic clear_sched();
    for (int i = 0; i < NS; i++) begin
      s_rd[i] = 0; s_wr[i] = 0; sh_on[i] = 0; s_addr[i] = '0;
      s_wd[i] = '0; s_be[i] = '0; idle_tag[i] = "R6";
    end
  endtask

  task automatic drive(int n);
    rd_sel = s_rd[n]; wr_sel = s_wr[n]; addr = s_addr[n];
    wr_data = s_wd[n]; wr_be = s_be[n];
    if (n == toggle_at) legacy_mode = ~legacy_mode;
  endtask

  always @(negedge clk) begin
    if (rst_n && tk >= 0) begin
      int n;
      logic ev;
      logic [35:0] ed;
      string tv, td;
      n = tk;
      if (sh_on[n]) shadow[sh_idx[n]] = bmerge(shadow[sh_idx[n]], sh_d[n], sh_be[n]);
      while (q.size() > 0 && q[0].first + 3 < n) void'(q.pop_front());
      ev = 0; ed = '0; tv = idle_tag[n]; td = idle_tag[n];
      foreach (q[i]) begin
        if (n >= q[i].first - 1 && n <= q[i].first + 2) begin ev = 1; tv = q[i].tag; end
        if (n >= q[i].first && n <= q[i].first + 3) begin
          ed = shadow[q[i].loc * 4 + n - q[i].first];
          td = q[i].tag;
        end
      end
      chk(tv, $sformatf("rd_valid tick %0d", n), {35'b0, rd_valid}, {35'b0, ev});
      chk(td, $sformatf("rd_data tick %0d", n), rd_data, ed);
    end
  end

  task automatic run_phase(logic mode, int nt);
    rst_n = 0;
    legacy_mode = mode;
    repeat (4) @(negedge clk);
    chk("R1", "rd_valid in reset", {35'b0, rd_valid}, 36'd0);
    chk("R1", "rd_data in reset", rd_data, 36'd0);
    rst_n = 1;
    drive(0);
    for (int n = 1; n <= nt; n++) begin
      @(negedge clk);
      drive(n);
    end
    chk("R4", "all reads drained", 36'(q.size()), 36'd0);
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) shadow[i] = '0;
    q.delete();
    clear_sched();
    repeat (2) @(negedge clk);
    sched_write(0, 1, 1, 16'hFFFF);
    sched_write(4, 2, 2, 16'hFFFF);
    sched_write(8, 3, 3, 16'hFFFF);
    sched_read(8, 1, 5, "R4");
    sched_write(12, 3, 4, 16'h5A3C);
    sched_read(12, 2, 5, "R8");
    sched_write(16, 5, 5, 16'hFFFF);
    sched_write(20, 6, 6, 16'hFFFF);
    sched_read(20, 3, 5, "R3");
    sched_write(24, 7, 7, 16'hFFFF);
    sched_write(28, 8, 8, 16'hFFFF);
    sched_write(32, 10, 9, 16'hFFFF);
    sched_read(32, 5, 5, "R9");
    sched_read(40, 5, 5, "R10");
    sched_write(44, 5, 10, 16'h9F6E);
    sched_read(56, 6, 5, "R10");
    sched_write(62, 6, 11, 16'hFFFF);
    sched_read(72, 1, 5, "R7");
    s_rd[74] = 1; s_addr[74] = 6'(2 * 4);
    mark_quiet(78, 82);
    sched_read(80, 10, 5, "R9");
    sched_write(88, 7, 12, 16'hFFFF);
    s_wr[90] = 1; s_addr[91] = 6'(8 * 4);
    s_wd[93] = '0; s_be[93] = 4'hF; s_wd[94] = '0; s_be[94] = 4'hF;
    sched_read(96, 7, 5, "R2");
    sched_read(100, 8, 5, "R7");
    s_rd[109] = 1; s_addr[109] = 6'(1 * 4);
    mark_quiet(112, 120);
    run_phase(1'b0, 130);

    q.delete();
    clear_sched();
    toggle_at = 20;
    sched_write(0, 9, 20, 16'hFFFF);
    sched_read(4, 9, 3, "R5");
    sched_read(8, 1, 3, "R8");
    sched_read(12, 2, 3, "R10");
    sched_write(14, 2, 21, 16'h3CF0);
    sched_read(24, 9, 3, "R10");
    sched_write(24, 9, 22, 16'hFFFF);
    sched_read(32, 3, 3, "R11");
    sched_write(36, 3, 23, 16'hFFFF);
    sched_read(44, 2, 3, "R11");
    sched_read(48, 3, 3, "R11");
    sched_read(56, 8, 3, "R5");
    s_rd[58] = 1; s_addr[58] = 6'(9 * 4);
    mark_quiet(62, 65);
    run_phase(1'b1, 80);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule